// File: doc/BRIEF.md
# Dual-Image Reconfiguration Register File Controller

This block holds the register set that a fallback-capable configuration manager uses to choose which stored image the device loads next. There are two images. A factory image lives at page 0 and acts as the safe fallback. Application images live on the other pages. The block keeps four registers:

- a control register that describes the image now loaded;
- an update register that the factory image fills in to pick the next application;
- a status register that records why the last reconfiguration happened;
- a 22-bit serial shift register through which core logic reads and writes the others.

A reconfiguration request from the factory image launches the application named in the update register. A request from an application, an error, or a watchdog expiry sends the device back to the factory page.

A sequencer with three states drives the block:

- **ST_CONFIG**: an image is being loaded.
- **ST_USER**: the loaded image is running.
- **ST_RECONF**: a single cycle in which a new reconfiguration is launched.

It has these transitions:

- **T_LOADED**: ST_CONFIG to ST_USER, on `load_done`.
- **T_FAULT**: ST_CONFIG to ST_RECONF, on a CRC error, a status-pin error or an external request.
- **T_TRIGGER**: ST_USER to ST_RECONF, on any cause.
- **T_RESTART**: ST_RECONF to ST_CONFIG, always.

The static `remote_mode` input chooses remote operation (seven application pages) or local operation (a single application at page 1). Loading the bitstream itself is outside the block. Its completion is signalled by `load_done`.

Top module: `cfg_image_regfile`

## Requirements
- R1: After reset the control register holds the application flag at 0, the watchdog disabled and the timeout at 0. Its page is 000 in remote mode and 001 in local mode. The status register is 00000. `page_sel` and `image_app` show the control page and the control flag.
- R2: A serial access happens only on a clock edge with `acc_en` high. With `shift_en` high, the shift register moves one place toward bit 0, `ser_in` enters bit 21, and `ser_out` always shows bit 0, so data leaves LSB first.
- R3: A capture is a serial access with `shift_en` low and `capture_sel` high. It loads bits [4:0] with the status register and bits [21:5] with a 17-bit register word. That word is the update register in the factory image and the control register in the application image. The word layout is: bit 5 application flag, bits [8:6] page, bit 9 watchdog enable, bits [21:10] timeout.
- R4: An update is a serial access with `shift_en` low and `capture_sel` low. It copies shift bits [21:5] into the update register when the factory image is loaded in remote mode.
- R5: An update has no effect in the application image or in local mode.
- R6: `load_done` in ST_CONFIG moves the block to ST_USER (`user_mode` high). Every accepted cause moves it to ST_RECONF, where `reconfig_pulse` is high for exactly one cycle, and then on to ST_CONFIG.
- R7: A core request from the factory image in remote mode loads the control register from the update register with the application flag forced to 1.
- R8: A core request from an application image, an error, or a watchdog expiry loads the factory setting: page 000, flag 0, watchdog off, timeout 0. In remote mode an external request does the same.
- R9: The status register is rewritten on every reconfiguration with exactly the causes accepted in that cycle. Bit 0 is CRC error, bit 1 status-pin error, bit 2 core request, bit 3 external request and bit 4 watchdog expiry.
- R10: In remote mode, in the application image, with the watchdog enabled and in ST_USER, the watchdog expires after timeout × 2^WD_FRAC cycles without a `wd_kick`. Each kick reloads the full count.
- R11: In ST_CONFIG only CRC errors, status-pin errors and external requests are accepted. Core requests are ignored there.
- R12: When several causes arrive together, errors outrank the external request, and the external request outranks the core request, in choosing the next control value.
- R13: In local mode, an external request and a factory core request both load page 001 with the flag at 1. An application core request returns to page 000. The watchdog never expires in local mode.
- R14: With `acc_en` low, the shift register and `ser_out` hold their values whatever the other access inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| remote_mode | input | 1 | 1 = remote operation, 0 = local operation (static) |
| acc_en | input | 1 | Qualifies a serial access on this edge |
| shift_en | input | 1 | 1 = shift, 0 = capture or update |
| capture_sel | input | 1 | With `shift_en` low: 1 = capture, 0 = update |
| ser_in | input | 1 | Serial data into bit 21 |
| ser_out | output | 1 | Serial data from bit 0 |
| load_done | input | 1 | Image load finished |
| err_crc | input | 1 | CRC error pulse |
| err_status | input | 1 | Status-pin error pulse |
| core_reconfig | input | 1 | Reconfiguration request from user logic |
| ext_reconfig | input | 1 | External reconfiguration request |
| wd_kick | input | 1 | Watchdog reload |
| page_sel | output | 3 | Page to load |
| image_app | output | 1 | 1 = application image loaded |
| user_mode | output | 1 | Loaded image is running |
| reconfig_pulse | output | 1 | One-cycle reconfiguration start |

## Verification
The assertions check four properties on every cycle:

- each reconfiguration pulse lasts one cycle and returns the block to ST_CONFIG;
- the page output only changes together with that pulse, and every return to the factory image lands on page 0;
- user mode is entered only after `load_done`;
- the serial output stays frozen without an access strobe, and the watchdog stays silent in local mode.

Other behaviour needs the bench's directed scenarios: which register a capture returns, the serial bit layout, an update ignored in the application image and seen only later from the factory, the exact cycle of a watchdog expiry, the priority between simultaneous causes, and the choice of page in local mode.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
    localparam int PAGE_W = 3;
    localparam int TMO_W  = 12;
    localparam int STAT_W = 5;

    // Cause bit positions inside the status register
    localparam int CZ_CRC  = 0;
    localparam int CZ_STAT = 1;
    localparam int CZ_CORE = 2;
    localparam int CZ_EXT  = 3;
    localparam int CZ_WD   = 4;

    typedef struct packed {
        logic [TMO_W-1:0]  tmo;
        logic              wd_en;
        logic [PAGE_W-1:0] page;
        logic              is_app;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int SR_W   = CTRL_W + STAT_W;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_USER   = 2'd1,
        ST_RECONF = 2'd2
    } seq_state_t;

    function automatic ctrl_t por_ctrl(input logic remote);
        ctrl_t c;
        c.tmo    = '0;
        c.wd_en  = 1'b0;
        c.page   = remote ? PAGE_W'(0) : PAGE_W'(1);
        c.is_app = 1'b0;
        return c;
    endfunction

    function automatic ctrl_t factory_ctrl();
        ctrl_t c;
        c.tmo    = '0;
        c.wd_en  = 1'b0;
        c.page   = '0;
        c.is_app = 1'b0;
        return c;
    endfunction

    function automatic ctrl_t local_app_ctrl();
        ctrl_t c;
        c.tmo    = '0;
        c.wd_en  = 1'b0;
        c.page   = PAGE_W'(1);
        c.is_app = 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/cfgr_shift_port.sv
module cfgr_shift_port
    import cfgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              remote_mode,
    input  logic              acc_en,
    input  logic              shift_en,
    input  logic              capture_sel,
    input  logic              ser_in,
    input  ctrl_t             ctrl_q,
    input  logic [STAT_W-1:0] status_q,
    output ctrl_t             upd_q,
    output logic              ser_out
);
    logic [SR_W-1:0] sr_q;
    logic            do_shift, do_capture, do_update, upd_allowed;
    ctrl_t           cap_word;

    always_comb begin
        do_shift    = acc_en && shift_en;
        do_capture  = acc_en && !shift_en && capture_sel;
        upd_allowed = remote_mode && !ctrl_q.is_app;
        do_update   = acc_en && !shift_en && !capture_sel && upd_allowed;
        cap_word    = ctrl_q.is_app ? ctrl_q : upd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (do_shift) begin
            sr_q <= {ser_in, sr_q[SR_W-1:1]};
        end else if (do_capture) begin
            sr_q <= {cap_word, status_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= por_ctrl(remote_mode);
        end else if (do_update) begin
            upd_q <= sr_q[SR_W-1:STAT_W];
        end
    end

    assign ser_out = sr_q[0];
endmodule

// File: rtl/cfgr_watchdog.sv
module cfgr_watchdog #(
    parameter int TMO_W   = 12,
    parameter int WD_FRAC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             kick,
    input  logic [TMO_W-1:0] tmo,
    output logic             expire
);
    localparam int CNT_W = TMO_W + WD_FRAC;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(tmo) << WD_FRAC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || kick) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = active && !kick && (cnt_q == '0);
endmodule

// File: rtl/cfgr_seq.sv
module cfgr_seq
    import cfgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              remote_mode,
    input  logic              load_done,
    input  logic              err_crc,
    input  logic              err_status,
    input  logic              core_reconfig,
    input  logic              ext_reconfig,
    input  logic              wd_expire,
    input  ctrl_t             upd_q,
    output ctrl_t             ctrl_q,
    output logic [STAT_W-1:0] status_q,
    output logic              wd_active,
    output logic              user_mode,
    output logic              reconfig_pulse
);
    seq_state_t       state_q, state_d;
    logic [STAT_W-1:0] cause;
    logic              trigger, any_err;
    ctrl_t             ctrl_d;

    // Causes accepted in the present state
    always_comb begin
        cause = '0;
        unique case (state_q)
            ST_CONFIG: begin
                cause[CZ_CRC]  = err_crc;
                cause[CZ_STAT] = err_status;
                cause[CZ_EXT]  = ext_reconfig;
            end
            ST_USER: begin
                cause[CZ_CRC]  = err_crc;
                cause[CZ_STAT] = err_status;
                cause[CZ_CORE] = core_reconfig;
                cause[CZ_EXT]  = ext_reconfig;
                cause[CZ_WD]   = wd_expire;
            end
            ST_RECONF: cause = '0;
            default:   cause = '0;
        endcase
        trigger = |cause;
        any_err = cause[CZ_CRC] | cause[CZ_STAT] | cause[CZ_WD];
    end

    // Next control word: errors, then external request, then core request
    always_comb begin
        ctrl_d = factory_ctrl();
        if (any_err) begin
            ctrl_d = factory_ctrl();
        end else if (cause[CZ_EXT]) begin
            ctrl_d = remote_mode ? factory_ctrl() : local_app_ctrl();
        end else if (cause[CZ_CORE]) begin
            if (ctrl_q.is_app) begin
                ctrl_d = factory_ctrl();
            end else if (remote_mode) begin
                ctrl_d        = upd_q;
                ctrl_d.is_app = 1'b1;
            end else begin
                ctrl_d = local_app_ctrl();
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG: begin
                if (trigger)        state_d = ST_RECONF;
                else if (load_done) state_d = ST_USER;
            end
            ST_USER:   if (trigger) state_d = ST_RECONF;
            ST_RECONF: state_d = ST_CONFIG;
            default:   state_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= por_ctrl(remote_mode);
            status_q <= '0;
        end else if (trigger) begin
            ctrl_q   <= ctrl_d;
            status_q <= cause;
        end
    end

    always_comb begin
        user_mode      = (state_q == ST_USER);
        reconfig_pulse = (state_q == ST_RECONF);
        wd_active      = user_mode && remote_mode && ctrl_q.is_app && ctrl_q.wd_en;
    end
endmodule

// File: rtl/cfg_image_regfile.sv
module cfg_image_regfile
    import cfgr_pkg::*;
#(
    parameter int WD_FRAC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              remote_mode,
    input  logic              acc_en,
    input  logic              shift_en,
    input  logic              capture_sel,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              load_done,
    input  logic              err_crc,
    input  logic              err_status,
    input  logic              core_reconfig,
    input  logic              ext_reconfig,
    input  logic              wd_kick,
    output logic [PAGE_W-1:0] page_sel,
    output logic              image_app,
    output logic              user_mode,
    output logic              reconfig_pulse
);
    ctrl_t             ctrl_q, upd_q;
    logic [STAT_W-1:0] status_q;
    logic              wd_active, wd_expire;

    cfgr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .remote_mode(remote_mode), .load_done(load_done),
        .err_crc(err_crc), .err_status(err_status), .core_reconfig(core_reconfig),
        .ext_reconfig(ext_reconfig), .wd_expire(wd_expire), .upd_q(upd_q),
        .ctrl_q(ctrl_q), .status_q(status_q), .wd_active(wd_active),
        .user_mode(user_mode), .reconfig_pulse(reconfig_pulse)
    );

    cfgr_shift_port u_port (
        .clk(clk), .rst_n(rst_n), .remote_mode(remote_mode), .acc_en(acc_en),
        .shift_en(shift_en), .capture_sel(capture_sel), .ser_in(ser_in),
        .ctrl_q(ctrl_q), .status_q(status_q), .upd_q(upd_q), .ser_out(ser_out)
    );

    cfgr_watchdog #(.TMO_W(TMO_W), .WD_FRAC(WD_FRAC)) u_wd (
        .clk(clk), .rst_n(rst_n), .active(wd_active), .kick(wd_kick),
        .tmo(ctrl_q.tmo), .expire(wd_expire)
    );

    assign page_sel  = ctrl_q.page;
    assign image_app = ctrl_q.is_app;
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       remote_mode,
    input logic       acc_en,
    input logic       ser_out,
    input logic       load_done,
    input logic       reconfig_pulse,
    input logic [2:0] page_sel,
    input logic       image_app,
    input logic       user_mode,
    input logic       wd_expire
);
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig_pulse |=> (!reconfig_pulse && !user_mode));

    p_user_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_mode) |-> $past(load_done));

    p_page_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_sel) |-> reconfig_pulse);

    p_factory_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reconfig_pulse && !image_app) |-> (page_sel == 3'd0));

    p_no_wd_local_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !remote_mode |-> !wd_expire);

    p_hold_port_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(ser_out));
endmodule

bind cfg_image_regfile cfgr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .remote_mode(remote_mode), .acc_en(acc_en),
    .ser_out(ser_out), .load_done(load_done), .reconfig_pulse(reconfig_pulse),
    .page_sel(page_sel), .image_app(image_app), .user_mode(user_mode),
    .wd_expire(wd_expire)
);

// File: tb/cfg_image_regfile_test.sv
`timescale 1ns/1ps
module cfg_image_regfile_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic remote_mode = 1'b1;
    logic acc_en = 1'b0, shift_en = 1'b0, capture_sel = 1'b0, ser_in = 1'b0;
    logic load_done = 1'b0, err_crc = 1'b0, err_status = 1'b0;
    logic core_reconfig = 1'b0, ext_reconfig = 1'b0, wd_kick = 1'b0;
    logic       ser_out, image_app, user_mode, reconfig_pulse;
    logic [2:0] page_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cfg_image_regfile #(.WD_FRAC(2)) uut (
        .clk(clk), .rst_n(rst_n), .remote_mode(remote_mode), .acc_en(acc_en),
        .shift_en(shift_en), .capture_sel(capture_sel), .ser_in(ser_in),
        .ser_out(ser_out), .load_done(load_done), .err_crc(err_crc),
        .err_status(err_status), .core_reconfig(core_reconfig),
        .ext_reconfig(ext_reconfig), .wd_kick(wd_kick), .page_sel(page_sel),
        .image_app(image_app), .user_mode(user_mode), .reconfig_pulse(reconfig_pulse)
    );

    function automatic logic [16:0] word(input logic [11:0] tmo, input logic wd,
                                          input logic [2:0] pg, input logic app);
        return {tmo, wd, pg, app};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic remote);
        rst_n = 1'b0;
        remote_mode = remote;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic capture();
        acc_en = 1'b1; shift_en = 1'b0; capture_sel = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; capture_sel = 1'b0;
    endtask

    task automatic shift_out(output logic [21:0] v);
        for (int i = 0; i < 22; i++) begin
            v[i] = ser_out;
            ser_in = 1'b0; acc_en = 1'b1; shift_en = 1'b1;
            @(negedge clk);
        end
        acc_en = 1'b0; shift_en = 1'b0;
    endtask

    task automatic read_regs(input string req, input logic [21:0] exp);
        logic [21:0] v;
        capture();
        shift_out(v);
        check(req, 32'(v), 32'(exp));
    endtask

    task automatic write_update(input logic [16:0] w);
        logic [21:0] full;
        full = {w, 5'b0};
        for (int i = 0; i < 22; i++) begin
            ser_in = full[i]; acc_en = 1'b1; shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0; capture_sel = 1'b0; acc_en = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; ser_in = 1'b0;
    endtask

    task automatic go_user();
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        check("R6 user after load_done", 32'(user_mode), 1);
    endtask

    // Drive a cause vector {wd-none, ext, core, stat, crc} for one cycle, expect a pulse
    task automatic fire(input string req, input logic crc, input logic st,
                        input logic core, input logic ext);
        err_crc = crc; err_status = st; core_reconfig = core; ext_reconfig = ext;
        @(negedge clk);
        err_crc = 0; err_status = 0; core_reconfig = 0; ext_reconfig = 0;
        check({req, " pulse high"}, 32'(reconfig_pulse), 1);
        @(negedge clk);
        check({req, " pulse one cycle"}, 32'(reconfig_pulse), 0);
        check({req, " back to config"}, 32'(user_mode), 0);
    endtask

    task automatic t_reset();
        logic [21:0] v;
        do_reset(1'b1);
        check("R1 page", 32'(page_sel), 0);
        check("R1 flag", 32'(image_app), 0);
        check("R1 user", 32'(user_mode), 0);
        capture();
        // R14: strobe low, other access lines busy
        for (int i = 0; i < 5; i++) begin
            shift_en = 1'b1; ser_in = 1'b1; capture_sel = i[0];
            @(negedge clk);
            check("R14 ser_out held", 32'(ser_out), 0);
        end
        shift_en = 1'b0; ser_in = 1'b0; capture_sel = 1'b0;
        shift_out(v);
        check("R1 R14 regs at reset", 32'(v), 0);
    endtask

    task automatic t_update_write();
        go_user();
        write_update(word(12'd3, 1'b1, 3'd5, 1'b0));
        read_regs("R2 R3 R4 factory capture", {word(12'd3, 1'b1, 3'd5, 1'b0), 5'b00000});
    endtask

    task automatic t_core_launch();
        fire("R7 core launch", 0, 0, 1, 0);
        check("R7 page", 32'(page_sel), 5);
        check("R7 flag", 32'(image_app), 1);
        read_regs("R3 R9 app capture", {word(12'd3, 1'b1, 3'd5, 1'b1), 5'b00100});
    endtask

    task automatic t_app_update_ignored();
        write_update(word(12'hABC, 1'b0, 3'd2, 1'b0));
        read_regs("R5 app control unchanged", {word(12'd3, 1'b1, 3'd5, 1'b1), 5'b00100});
    endtask

    task automatic t_watchdog();
        int n;
        go_user();
        for (int k = 0; k < 5; k++) begin
            wd_kick = 1'b1;
            @(negedge clk);
            wd_kick = 1'b0;
            repeat (8) begin
                @(negedge clk);
                check("R10 no expiry while kicked", 32'(reconfig_pulse), 0);
            end
        end
        wd_kick = 1'b1;
        @(negedge clk);
        wd_kick = 1'b0;
        n = 0;
        while (!reconfig_pulse && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R10 expiry cycle", 32'(n), 13);
        check("R8 wd page", 32'(page_sel), 0);
        check("R8 wd flag", 32'(image_app), 0);
        @(negedge clk);
        read_regs("R5 R9 update kept, wd cause", {word(12'd3, 1'b1, 3'd5, 1'b0), 5'b10000});
    endtask

    task automatic t_causes();
        logic [16:0] w1;
        w1 = word(12'd3, 1'b1, 3'd5, 1'b0);
        fire("R11 crc in config", 1, 0, 0, 0);
        read_regs("R9 crc cause", {w1, 5'b00001});
        core_reconfig = 1'b1;
        @(negedge clk);
        core_reconfig = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R11 core ignored in config", 32'(reconfig_pulse), 0);
        end
        go_user();
        fire("R8 ext remote", 0, 0, 0, 1);
        check("R8 ext page", 32'(page_sel), 0);
        read_regs("R9 ext cause", {w1, 5'b01000});
        go_user();
        fire("R12 core+crc", 1, 0, 1, 0);
        check("R12 page", 32'(page_sel), 0);
        check("R12 flag", 32'(image_app), 0);
        read_regs("R12 R9 both causes", {w1, 5'b00101});
        go_user();
        fire("R7 relaunch", 0, 0, 1, 0);
        check("R7 relaunch page", 32'(page_sel), 5);
        go_user();
        fire("R8 status err in app", 0, 1, 0, 0);
        check("R8 status page", 32'(page_sel), 0);
        read_regs("R9 status cause", {w1, 5'b00010});
    endtask

    task automatic t_local();
        logic [16:0] por;
        do_reset(1'b0);
        por = word(12'd0, 1'b0, 3'd1, 1'b0);
        check("R1 local page", 32'(page_sel), 1);
        check("R1 local flag", 32'(image_app), 0);
        go_user();
        write_update(word(12'h5A5, 1'b1, 3'd6, 1'b0));
        read_regs("R5 local update ignored", {por, 5'b00000});
        fire("R13 local factory core", 0, 0, 1, 0);
        check("R13 local app page", 32'(page_sel), 1);
        check("R13 local app flag", 32'(image_app), 1);
        read_regs("R13 local app capture", {word(12'd0, 1'b0, 3'd1, 1'b1), 5'b00100});
        go_user();
        repeat (30) @(negedge clk);
        check("R13 no watchdog local", 32'(reconfig_pulse), 0);
        fire("R13 local app core", 0, 0, 1, 0);
        check("R13 back to factory", 32'(page_sel), 0);
        check("R13 factory flag", 32'(image_app), 0);
        go_user();
        fire("R13 local ext", 0, 0, 0, 1);
        check("R13 ext page", 32'(page_sel), 1);
        check("R13 ext flag", 32'(image_app), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_update_write();
        t_core_launch();
        t_app_update_ignored();
        t_watchdog();
        t_causes();
        t_local();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule